// File: doc/BRIEF.md
# Serial Flash Host Controller

This block is a serial-bus master that turns single-word requests into complete command frames for a small serial flash device. A requester presents an operation code, a 24-bit address, a data byte and a byte count on a valid/ready port. The block opens a chip-select window and clocks the needed bytes out in mode 0 (clock idles low, the device is sampled on the rising edge, most significant bit first). For a read, each byte it captures is returned with a one-cycle strobe.

A program or erase request is followed by a second chip-select window. In that window the block issues the status command once and then keeps clocking status bytes until bit 0 reads 1, which means ready. If that bit stays 0 for a parameterised number of status bytes, the block closes the window and sends a one-byte abort frame. It then reports the request as finished with an error. The serial clock is the system clock divided by a parameter. The deselect time between windows and the chip-select setup/hold time are also counts of system clocks set by parameters.

The erase frame carries the two upper address bytes, which name a 256-byte sector. A second confirm byte inside the same window protects against a stray erase.

Top module: `sflash_host`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, req_ready is 1, and done, err and rd_valid are 0.
- R2: spi_sck is 0 whenever spi_cs_n is 1, and spi_mosi changes only while spi_sck is 0. All frame bytes are sent most significant bit first. Received bits are taken on the rising edge of spi_sck.
- R3: Every high phase and every low phase of spi_sck lasts at least CLK_DIV system clocks.
- R4: Once spi_cs_n rises, it stays high for at least CS_IDLE_CYC system clocks before it falls again.
- R5: req_ready is 1 only when the block is idle. A request is taken on a cycle with req_valid and req_ready both 1, and no further request is taken until done. done is a single-cycle pulse, and req_ready is 1 in that same cycle.
- R6: The req_op encoding is 0 for read, 1 for write, 2 for erase, and 3 acts as read. A read is one window: 0xFF, address bits 23:16, 15:8 and 7:0, two 0x00 bytes, then req_len clocked bytes. Each received byte appears on rd_data with rd_valid high for one cycle, in order. A req_len of 0 gives a six-byte window.
- R7: A write window is exactly six bytes: 0x10, the three address bytes (high first), req_data, then 0x00.
- R8: An erase window is exactly six bytes: 0x20, address bits 23:16, address bits 15:8, 0x00, 0xD0, then 0x00.
- R9: After a write or erase window, the block opens one more window that starts with 0x9F and then carries status bytes. The window ends after the first status byte with bit 0 equal to 1. done then follows with err at 0, as long as fewer than POLL_LIMIT status bytes read busy.
- R10: If POLL_LIMIT status bytes in a row read busy (bit 0 = 0), the status window ends after exactly that many status bytes. The block then opens a window holding the single byte 0xFF, and done follows with err at 1.
- R11: err is 1 only in a cycle where done is 1.
- R12: rd_valid is 1 only while spi_cs_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken when valid is also high |
| req_op | input | 2 | 0 read, 1 write, 2 erase, 3 read |
| req_addr | input | 24 | Byte or sector address |
| req_data | input | 8 | Byte to program |
| req_len | input | LEN_W | Number of bytes to read |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| done | output | 1 | One-cycle pulse when a request finishes |
| err | output | 1 | Status timeout, valid with done |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
If the byte counter were wrong, a frame would end up the wrong length or put a field in the wrong slot. That would show in the byte list of the next window, and on reads it would show as shifted or missing rd_data bytes within the same request. If the phase sequencing were wrong, the status window would be skipped or repeated, or the abort frame would be missing. The window count and err seen at the following done pulse reveal this. Errors in clock or chip-select timing appear on the very next edge as a short phase or a short deselect gap.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
    localparam logic [1:0] OPC_READ  = 2'd0;
    localparam logic [1:0] OPC_WRITE = 2'd1;
    localparam logic [1:0] OPC_ERASE = 2'd2;

    localparam logic [7:0] CB_READ    = 8'hFF;
    localparam logic [7:0] CB_PROG    = 8'h10;
    localparam logic [7:0] CB_ERASE   = 8'h20;
    localparam logic [7:0] CB_CONFIRM = 8'hD0;
    localparam logic [7:0] CB_STATUS  = 8'h9F;
    localparam logic [7:0] CB_ABORT   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_SHIFT = 3'd2,
        ST_HOLD  = 3'd3,
        ST_GAP   = 3'd4
    } host_st_e;

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_POLL  = 2'd1,
        PH_ABORT = 2'd2
    } host_ph_e;
endpackage

// File: rtl/sflash_byte_io.sv
module sflash_byte_io #(
    parameter int CLK_DIV = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic          active;
        logic          sck;
        logic [2:0]    bitc;
        logic [DW-1:0] div;
        logic [7:0]    sreg;
        logic [7:0]    rx;
        logic          done;
    } io_t;

    io_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (start && !q.active) begin
            d.active = 1'b1;
            d.sreg   = tx;
            d.bitc   = 3'd0;
            d.sck    = 1'b0;
            d.div    = DW'(CLK_DIV - 1);
        end else if (q.active) begin
            if (q.div == '0) begin
                d.div = DW'(CLK_DIV - 1);
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = {q.rx[6:0], miso};
                end else begin
                    d.sck = 1'b0;
                    if (q.bitc == 3'd7) begin
                        d.active = 1'b0;
                        d.done   = 1'b1;
                    end else begin
                        d.bitc = q.bitc + 3'd1;
                        d.sreg = {q.sreg[6:0], 1'b0};
                    end
                end
            end else begin
                d.div = q.div - DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.sck;
    assign mosi = q.sreg[7];
    assign rx   = q.rx;
    assign done = q.done;
endmodule

// File: rtl/sflash_frame_byte.sv
module sflash_frame_byte
    import sflash_pkg::*;
#(
    parameter int IW = 11
) (
    input  host_ph_e      ph,
    input  logic [1:0]    op,
    input  logic [IW-1:0] idx,
    input  logic [23:0]   addr,
    input  logic [7:0]    data,
    output logic [7:0]    tx
);
    always_comb begin
        tx = 8'h00;
        unique case (ph)
            PH_POLL:  tx = (idx == '0) ? CB_STATUS : 8'h00;
            PH_ABORT: tx = CB_ABORT;
            default: begin
                if (op == OPC_ERASE) begin
                    case (idx)
                        IW'(0): tx = CB_ERASE;
                        IW'(1): tx = addr[23:16];
                        IW'(2): tx = addr[15:8];
                        IW'(4): tx = CB_CONFIRM;
                        default: tx = 8'h00;
                    endcase
                end else begin
                    case (idx)
                        IW'(0): tx = (op == OPC_WRITE) ? CB_PROG : CB_READ;
                        IW'(1): tx = addr[23:16];
                        IW'(2): tx = addr[15:8];
                        IW'(3): tx = addr[7:0];
                        IW'(4): tx = (op == OPC_WRITE) ? data : 8'h00;
                        default: tx = 8'h00;
                    endcase
                end
            end
        endcase
    end
endmodule

// File: rtl/sflash_host.sv
module sflash_host
    import sflash_pkg::*;
#(
    parameter int CLK_DIV      = 5,
    parameter int CS_IDLE_CYC  = 25,
    parameter int CS_SETUP_CYC = 40,
    parameter int POLL_LIMIT   = 200,
    parameter int LEN_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [7:0]       req_data,
    input  logic [LEN_W-1:0] req_len,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             err,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int IW    = LEN_W + 3;
    localparam int TMAX  = (CS_IDLE_CYC > CS_SETUP_CYC) ? CS_IDLE_CYC : CS_SETUP_CYC;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int PW    = $clog2(POLL_LIMIT + 1);
    localparam int HDR_N = 6;

    typedef struct packed {
        host_st_e         st;
        host_ph_e         ph;
        logic [1:0]       op;
        logic [23:0]      addr;
        logic [7:0]       data;
        logic [LEN_W-1:0] len;
        logic [IW-1:0]    idx;
        logic [TW-1:0]    tmr;
        logic [PW-1:0]    pcnt;
        logic             tmout;
        logic             cs_n;
        logic             kick;
        logic [7:0]       rd_data;
        logic             rd_valid;
        logic             done;
        logic             err;
    } host_t;

    host_t q, d;

    logic [7:0] tx_byte, rx_byte;
    logic       byte_done;
    logic       is_read;
    logic [IW-1:0] last_rd;

    sflash_frame_byte #(.IW(IW)) u_frame (
        .ph(q.ph), .op(q.op), .idx(q.idx), .addr(q.addr), .data(q.data), .tx(tx_byte)
    );

    sflash_byte_io #(.CLK_DIV(CLK_DIV)) u_io (
        .clk(clk), .rst_n(rst_n), .start(q.kick), .tx(tx_byte), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi), .rx(rx_byte), .done(byte_done)
    );

    assign is_read = (q.op != OPC_WRITE) && (q.op != OPC_ERASE);
    assign last_rd = IW'(HDR_N - 1) + IW'(q.len);

    always_comb begin
        d = q;
        d.kick     = 1'b0;
        d.rd_valid = 1'b0;
        d.done     = 1'b0;
        d.err      = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op    = req_op;
                    d.addr  = req_addr;
                    d.data  = req_data;
                    d.len   = req_len;
                    d.ph    = PH_CMD;
                    d.idx   = '0;
                    d.tmout = 1'b0;
                    d.cs_n  = 1'b0;
                    d.tmr   = TW'(CS_SETUP_CYC - 1);
                    d.st    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (q.tmr == '0) begin
                    d.kick = 1'b1;
                    d.st   = ST_SHIFT;
                end else begin
                    d.tmr = q.tmr - TW'(1);
                end
            end
            ST_SHIFT: begin
                if (byte_done) begin
                    d.tmr = TW'(CS_SETUP_CYC - 1);
                    unique case (q.ph)
                        PH_CMD: begin
                            if (is_read && q.idx >= IW'(HDR_N)) begin
                                d.rd_data  = rx_byte;
                                d.rd_valid = 1'b1;
                            end
                            if (q.idx == (is_read ? last_rd : IW'(HDR_N - 1))) begin
                                d.st = ST_HOLD;
                            end else begin
                                d.idx  = q.idx + IW'(1);
                                d.kick = 1'b1;
                            end
                        end
                        PH_POLL: begin
                            if (q.idx == '0) begin
                                d.idx  = IW'(1);
                                d.kick = 1'b1;
                            end else if (rx_byte[0]) begin
                                d.st = ST_HOLD;
                            end else if (q.pcnt == PW'(POLL_LIMIT - 1)) begin
                                d.tmout = 1'b1;
                                d.st    = ST_HOLD;
                            end else begin
                                d.pcnt = q.pcnt + PW'(1);
                                d.kick = 1'b1;
                            end
                        end
                        default: d.st = ST_HOLD;
                    endcase
                end
            end
            ST_HOLD: begin
                if (q.tmr == '0) begin
                    d.cs_n = 1'b1;
                    d.tmr  = TW'(CS_IDLE_CYC - 1);
                    d.st   = ST_GAP;
                end else begin
                    d.tmr = q.tmr - TW'(1);
                end
            end
            default: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TW'(1);
                end else if ((q.ph == PH_CMD && !is_read) || (q.ph == PH_POLL && q.tmout)) begin
                    d.ph   = (q.ph == PH_CMD) ? PH_POLL : PH_ABORT;
                    d.idx  = '0;
                    d.pcnt = '0;
                    d.cs_n = 1'b0;
                    d.tmr  = TW'(CS_SETUP_CYC - 1);
                    d.st   = ST_SETUP;
                end else begin
                    d.done = 1'b1;
                    d.err  = (q.ph == PH_ABORT);
                    d.st   = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rd_data   = q.rd_data;
    assign rd_valid  = q.rd_valid;
    assign done      = q.done;
    assign err       = q.err;
    assign spi_cs_n  = q.cs_n;
endmodule

// File: rtl/sflash_host_chk.sv
module sflash_host_chk #(
    parameter int CLK_DIV     = 5,
    parameter int CS_IDLE_CYC = 25
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic err,
    input logic rd_valid,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);
    logic        sck_p, cs_p;
    logic [15:0] sck_run, cs_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p   <= 1'b0;
            cs_p    <= 1'b1;
            sck_run <= '1;
            cs_run  <= '1;
        end else begin
            sck_p   <= spi_sck;
            cs_p    <= spi_cs_n;
            sck_run <= (spi_sck != sck_p) ? 16'd1 : ((sck_run == '1) ? sck_run : sck_run + 16'd1);
            cs_run  <= (spi_cs_n != cs_p) ? 16'd1 : ((cs_run == '1) ? cs_run : cs_run + 16'd1);
        end
    end

    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && sck_p) |-> $stable(spi_mosi));

    assert_sck_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck != sck_p) |-> (sck_run >= 16'(CLK_DIV)));

    assert_cs_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && cs_p) |-> (cs_run >= 16'(CS_IDLE_CYC)));

    assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_rdv_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n);
endmodule

bind sflash_host sflash_host_chk #(.CLK_DIV(CLK_DIV), .CS_IDLE_CYC(CS_IDLE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .err(err), .rd_valid(rd_valid), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/test_sflash_host.sv
module test_sflash_host;
    localparam int CLK_DIV = 3;
    localparam int CS_IDLE = 6;
    localparam int CS_SET  = 4;
    localparam int PLIM    = 12;
    localparam int LW      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic [LW-1:0] req_len = '0;
    logic [7:0] rd_data;
    logic rd_valid, done, err, spi_cs_n, spi_sck, spi_mosi;
    logic miso = 1'b0;

    always #5 clk = ~clk;

    sflash_host #(.CLK_DIV(CLK_DIV), .CS_IDLE_CYC(CS_IDLE), .CS_SETUP_CYC(CS_SET),
                  .POLL_LIMIT(PLIM), .LEN_W(LW)) i_sflash_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(miso)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // device model state
    logic [7:0] mem [0:4095];
    logic [7:0] refm [0:4095];
    logic [7:0] fb [0:7];
    logic [7:0] hb [0:7][0:7];
    int hl [0:7];
    int nb = 0, win = 0, busy = 0, busy_load = 0, pk = 0, k = 0, nfr = 0;
    logic [11:0] pa;
    logic [7:0] pd, sh, rb;
    logic cs_p = 1'b1, sck_p = 1'b0;
    int sck_run = 0, cs_run = 0, min_ph = 1000000, min_gap = 1000000, bad_rdv = 0;
    bit sck_seen = 0, cs_seen = 0;

    function automatic logic [7:0] resp(input int kb);
        logic [11:0] ix;
        if (fb[0] == 8'hFF && kb >= 6) begin
            ix = {fb[2][3:0], fb[3]} + 12'(kb - 6);
            return mem[ix];
        end
        if (fb[0] == 8'h9F && kb >= 1) return {7'd0, busy == 0};
        return 8'h00;
    endfunction

    task automatic commit();
        if (pk == 1) mem[pa] = pd;
        if (pk == 2) for (int i = 0; i < 256; i++) mem[pa | 12'(i)] = 8'hFF;
        pk = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_p && !spi_cs_n) begin
                nb = 0; miso = 1'b0;
                for (int i = 0; i < 8; i++) fb[i] = 8'h00;
            end
            if (!spi_cs_n && spi_sck && !sck_p) begin
                sh = {sh[6:0], spi_mosi};
                nb++;
                if (nb % 8 == 0) begin
                    k = nb / 8 - 1;
                    if (k < 8) fb[k] = sh;
                    if (k >= 1 && fb[0] == 8'h9F && busy > 0) begin
                        busy--;
                        if (busy == 0) commit();
                    end
                end
            end
            if (!spi_cs_n && !spi_sck && sck_p) begin
                rb = resp(nb / 8);
                miso = rb[7 - (nb % 8)];
            end
            if (!cs_p && spi_cs_n) begin
                nfr = nb / 8;
                hl[win % 8] = nfr;
                for (int j = 0; j < 8; j++) hb[win % 8][j] = fb[j];
                win++;
                if (nfr == 6 && fb[0] == 8'h10 && busy == 0) begin
                    pk = 1; pa = {fb[2][3:0], fb[3]}; pd = fb[4]; busy = busy_load;
                    if (busy == 0) commit();
                end else if (nfr == 6 && fb[0] == 8'h20 && fb[4] == 8'hD0 && busy == 0) begin
                    pk = 2; pa = {fb[2][3:0], 8'h00}; busy = busy_load;
                    if (busy == 0) commit();
                end else if (nfr == 1 && fb[0] == 8'hFF && busy > 0) begin
                    busy = 0; pk = 0;
                end
            end
            // timing monitors
            if (spi_sck != sck_p) begin
                if (sck_seen && sck_run < min_ph) min_ph = sck_run;
                sck_seen = 1; sck_run = 1;
            end else sck_run++;
            if (spi_cs_n != cs_p) begin
                if (!spi_cs_n && cs_seen && cs_run < min_gap) min_gap = cs_run;
                if (spi_cs_n) cs_seen = 1;
                cs_run = 1;
            end else cs_run++;
            if (rd_valid && spi_cs_n) bad_rdv++;
            cs_p = spi_cs_n; sck_p = spi_sck;
        end
    end

    function automatic logic [47:0] frame6(input int w);
        return {hb[w % 8][0], hb[w % 8][1], hb[w % 8][2], hb[w % 8][3], hb[w % 8][4], hb[w % 8][5]};
    endfunction

    logic [7:0] rd_buf [0:31];

    task automatic do_op(input logic [1:0] op, input logic [23:0] a, input logic [7:0] dat,
                         input int len, input int bsy, input bit expect_to);
        int w0, nrd;
        bit got_err;
        logic [47:0] ef;
        logic [11:0] ix;
        busy_load = bsy;
        w0 = win; nrd = 0; got_err = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R5 ready before request", req_ready, 1);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = dat; req_len = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R5 ready low after accept", req_ready, 0);
        forever begin
            @(negedge clk);
            if (rd_valid && nrd < 32) begin rd_buf[nrd] = rd_data; nrd++; end
            if (done) begin
                got_err = err;
                check(req_ready == 1'b1, "R5 ready with done", req_ready, 1);
                break;
            end
        end
        if (op == 2'd1 || op == 2'd2) begin
            if (op == 2'd1) ef = {8'h10, a[23:16], a[15:8], a[7:0], dat, 8'h00};
            else ef = {8'h20, a[23:16], a[15:8], 8'h00, 8'hD0, 8'h00};
            check(hl[w0 % 8] == 6 && frame6(w0) == ef, op == 2'd1 ? "R7 R2 write frame" : "R8 R2 erase frame",
                  frame6(w0), ef);
            check(hb[(w0 + 1) % 8][0] == 8'h9F, "R9 status command", hb[(w0 + 1) % 8][0], 8'h9F);
            if (expect_to) begin
                check(win - w0 == 3, "R10 window count", win - w0, 3);
                check(hl[(w0 + 1) % 8] == 1 + PLIM, "R10 status bytes", hl[(w0 + 1) % 8], 1 + PLIM);
                check(hl[(w0 + 2) % 8] == 1 && hb[(w0 + 2) % 8][0] == 8'hFF, "R10 abort frame",
                      {hl[(w0 + 2) % 8], hb[(w0 + 2) % 8][0]}, {32'd1, 8'hFF});
                check(got_err == 1'b1, "R10 R11 err on timeout", got_err, 1);
            end else begin
                check(win - w0 == 2, "R9 window count", win - w0, 2);
                check(hl[(w0 + 1) % 8] == bsy + 2, "R9 status bytes", hl[(w0 + 1) % 8], bsy + 2);
                check(got_err == 1'b0, "R9 R11 no err", got_err, 0);
                if (op == 2'd1) refm[a[11:0]] = dat;
                else for (int i = 0; i < 256; i++) refm[{a[11:8], 8'h00} | 12'(i)] = 8'hFF;
            end
        end else begin
            ef = {8'hFF, a[23:16], a[15:8], a[7:0], 8'h00, 8'h00};
            check(win - w0 == 1 && hl[w0 % 8] == 6 + len, "R6 read window length", hl[w0 % 8], 6 + len);
            check(frame6(w0) == ef, "R6 R2 read header", frame6(w0), ef);
            check(nrd == len, "R6 rd_valid count", nrd, len);
            for (int i = 0; i < len && i < nrd; i++) begin
                ix = a[11:0] + 12'(i);
                check(rd_buf[i] == refm[ix], "R6 R2 read data", rd_buf[i], refm[ix]);
            end
            check(got_err == 1'b0, "R11 no err on read", got_err, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seedv;
        logic [1:0] rop;
        logic [23:0] ra;
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'(i) ^ {4'(i >> 8), 4'h0} ^ 8'h3C;
            refm[i] = 8'(i) ^ {4'(i >> 8), 4'h0} ^ 8'h3C;
        end
        seedv = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && req_ready == 1'b1 && !done && !err && !rd_valid,
              "R1 reset state", {spi_cs_n, spi_sck, req_ready, done, err, rd_valid}, 6'b101000);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n == 1'b1 && req_ready == 1'b1, "R1 idle after reset", {spi_cs_n, req_ready}, 2'b11);

        do_op(2'd0, 24'h123456, 8'h00, 0, 0, 0);
        do_op(2'd0, 24'hAB0FF8, 8'h00, 15, 0, 0);
        do_op(2'd3, 24'h000200, 8'h00, 3, 0, 0);
        do_op(2'd1, 24'h000010, 8'hA5, 0, 0, 0);
        do_op(2'd0, 24'h00000F, 8'h00, 3, 0, 0);
        do_op(2'd2, 24'h000300, 8'h00, 0, PLIM - 1, 0);
        do_op(2'd0, 24'h0003FE, 8'h00, 4, 0, 0);
        do_op(2'd2, 24'h000100, 8'h00, 0, 1000, 1);
        do_op(2'd0, 24'h0001FE, 8'h00, 4, 0, 0);
        do_op(2'd1, 24'h000105, 8'h3C, 0, 2, 0);
        do_op(2'd0, 24'h000104, 8'h00, 3, 0, 0);

        for (int it = 0; it < 20; it++) begin
            rop = 2'($urandom % 3);
            ra  = 24'($urandom);
            do_op(rop, ra, 8'($urandom), int'($urandom % 16), int'($urandom % 6), 0);
        end

        check(min_ph >= CLK_DIV, "R3 minimum sck phase", min_ph, CLK_DIV);
        check(min_gap >= CS_IDLE, "R4 minimum deselect gap", min_gap, CS_IDLE);
        check(bad_rdv == 0, "R12 rd_valid outside window", bad_rdv, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule